// File: doc/BRIEF.md
# Strobe-Aligned Codeword Receiver

This block recovers table indices from a 32-bit parallel input port driven by a remote controller. The controller toggles one port line at a fixed rate. Each transition of that line, rising or falling, marks one codeword slot. A second line says whether the slot carries a codeword. The remaining lines carry the codeword bits. Software chooses, at run time, which port line is the strobe, which line is the valid flag, and which bits form the codeword, given as a mask and a right shift.

The receiver runs on a fast local clock and passes the whole port through a two-stage synchronizer. It detects strobe transitions by comparing successive synchronized strobe values. After a programmable number of local cycles, it samples the valid bit and the codeword field, so that bits arriving slightly before or after the strobe are still captured. An accepted slot gives a one-cycle index pulse. If the strobe goes quiet for longer than a programmable limit, a sticky error flag is raised.

Top module: `cwlink_rx`

## Requirements
- R1: After reset, `idx_o` is 0, `idx_vld_o` is 0 and `err_o` is 0.
- R2: The strobe is the port bit at position `strobe_sel_i`, and every change of its level, whether 0 to 1 or 1 to 0, opens one codeword slot.
- R3: The valid flag is the port bit at position `valid_sel_i`. A slot in which that bit is 0 gives no pulse on `idx_vld_o` and leaves `idx_o` unchanged.
- R4: For an accepted slot, `idx_o` is bits 9..0 of `(port & mask_i) >> shift_i`. Port bits outside the mask have no effect, and result bits above bit 9 are dropped.
- R5: Take P as the rising clock edge that first captures the strobe change, counted as edge 1. The valid bit and the codeword are taken from the port as it stood at edge `settle_i + 2`. `idx_vld_o` is high exactly between edges `settle_i + 4` and `settle_i + 5`.
- R6: `idx_vld_o` is high for exactly one clock cycle for each accepted slot.
- R7: When `timeout_i` is nonzero and no strobe change has been seen for more than `timeout_i` clock cycles, `err_o` goes to 1 and stays at 1 until it is cleared. A `timeout_i` of 0 disables the check.
- R8: A one-cycle pulse on `err_clr_i` drops `err_o` on the next clock edge and restarts the idle count from zero.
- R9: `idx_o` holds its value between accepted slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast local clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| port_i | input | 32 | Raw parallel port, asynchronous to `clk_i` |
| strobe_sel_i | input | 5 | Bit position of the strobe line |
| valid_sel_i | input | 5 | Bit position of the valid line |
| mask_i | input | 32 | Codeword field mask |
| shift_i | input | 5 | Right shift applied after masking |
| settle_i | input | 4 | Local cycles to wait after a strobe edge before sampling |
| timeout_i | input | 16 | Strobe idle limit in cycles, 0 disables |
| err_clr_i | input | 1 | Clears the idle error flag |
| idx_o | output | 10 | Last accepted codeword index |
| idx_vld_o | output | 1 | One-cycle pulse for each accepted slot |
| err_o | output | 1 | Sticky strobe idle error |

## Verification
Slots are sent on both a rising and a falling strobe transition. This shows that both directions are detected and not only one. Stray bits are placed outside the mask, and a full mask is used with a nonzero shift, which separates correct masking and truncation from raw port forwarding. A slot with the valid bit low shows that the index register is gated and not merely the pulse. Late-arriving codeword bits are sent with settle values of zero and three, which shows whether the sampling point really follows the settle setting. The idle error is driven through timeout, hold, clear, restart and a run of regular strobe toggles.

// File: rtl/cwlink_pkg.sv
package cwlink_pkg;
    localparam int PORT_W = 32;
    localparam int IDX_W  = 10;
    localparam int SEL_W  = $clog2(PORT_W);
    localparam int SET_W  = 4;
    localparam int TO_W   = 16;
endpackage

// File: rtl/cwlink_sync.sv
module cwlink_sync #(
    parameter int W = cwlink_pkg::PORT_W
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = async_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign sync_o = st_q.s2;
endmodule

// File: rtl/cwlink_timer.sv
module cwlink_timer #(
    parameter int PORT_W = cwlink_pkg::PORT_W,
    parameter int SET_W  = cwlink_pkg::SET_W,
    parameter int TO_W   = cwlink_pkg::TO_W,
    localparam int SEL_W = $clog2(PORT_W)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [PORT_W-1:0] port_sync_i,
    input  logic [SEL_W-1:0]  strobe_sel_i,
    input  logic [SET_W-1:0]  settle_i,
    input  logic [TO_W-1:0]   timeout_i,
    input  logic              err_clr_i,
    output logic              sample_o,
    output logic              err_o
);
    typedef struct packed {
        logic             prev;
        logic             armed;
        logic [SET_W-1:0] cnt;
        logic [TO_W-1:0]  idle;
        logic             err;
    } tmr_t;

    tmr_t t_d, t_q;
    logic stb_lvl, stb_edge, sample;

    always_comb begin
        stb_lvl  = port_sync_i[strobe_sel_i];
        stb_edge = stb_lvl ^ t_q.prev;
        sample   = t_q.armed && (t_q.cnt == '0);

        t_d      = t_q;
        t_d.prev = stb_lvl;

        // settle countdown between strobe edge and sampling point
        if (stb_edge) begin
            t_d.armed = 1'b1;
            t_d.cnt   = settle_i;
        end else if (sample) begin
            t_d.armed = 1'b0;
        end else if (t_q.armed) begin
            t_d.cnt = t_q.cnt - SET_W'(1);
        end

        // idle watch on the strobe
        if (stb_edge || err_clr_i) t_d.idle = '0;
        else if (t_q.idle < timeout_i) t_d.idle = t_q.idle + TO_W'(1);

        if (err_clr_i) t_d.err = 1'b0;
        else if ((timeout_i != '0) && (t_q.idle >= timeout_i)) t_d.err = 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) t_q <= '0;
        else         t_q <= t_d;
    end

    assign sample_o = sample;
    assign err_o    = t_q.err;

    a_r7_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (t_q.err && !err_clr_i) |=> t_q.err);

    a_r8_err_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_clr_i |=> !t_q.err);

    a_r5_settle_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stb_edge |=> (t_q.armed && t_q.cnt == $past(settle_i)));

    a_r6_sample_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sample && !stb_edge) |=> !sample);
endmodule

// File: rtl/cwlink_extract.sv
module cwlink_extract #(
    parameter int PORT_W = cwlink_pkg::PORT_W,
    parameter int IDX_W  = cwlink_pkg::IDX_W,
    localparam int SEL_W = $clog2(PORT_W)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [PORT_W-1:0] port_sync_i,
    input  logic              sample_i,
    input  logic [SEL_W-1:0]  valid_sel_i,
    input  logic [PORT_W-1:0] mask_i,
    input  logic [SEL_W-1:0]  shift_i,
    output logic [IDX_W-1:0]  idx_o,
    output logic              idx_vld_o
);
    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             vld;
    } ext_t;

    ext_t x_d, x_q;
    logic vbit, take;

    always_comb begin
        vbit    = port_sync_i[valid_sel_i];
        take    = sample_i && vbit;
        x_d     = x_q;
        x_d.vld = take;
        if (take) x_d.idx = IDX_W'((port_sync_i & mask_i) >> shift_i);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) x_q <= '0;
        else         x_q <= x_d;
    end

    assign idx_o     = x_q.idx;
    assign idx_vld_o = x_q.vld;

    a_r3_no_pulse_when_invalid: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sample_i && !vbit) |=> !x_q.vld);

    a_r9_index_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(sample_i && vbit) |=> $stable(x_q.idx));
endmodule

// File: rtl/cwlink_rx.sv
module cwlink_rx #(
    parameter int PORT_W = cwlink_pkg::PORT_W,
    parameter int IDX_W  = cwlink_pkg::IDX_W,
    parameter int SET_W  = cwlink_pkg::SET_W,
    parameter int TO_W   = cwlink_pkg::TO_W,
    localparam int SEL_W = $clog2(PORT_W)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [PORT_W-1:0] port_i,
    input  logic [SEL_W-1:0]  strobe_sel_i,
    input  logic [SEL_W-1:0]  valid_sel_i,
    input  logic [PORT_W-1:0] mask_i,
    input  logic [SEL_W-1:0]  shift_i,
    input  logic [SET_W-1:0]  settle_i,
    input  logic [TO_W-1:0]   timeout_i,
    input  logic              err_clr_i,
    output logic [IDX_W-1:0]  idx_o,
    output logic              idx_vld_o,
    output logic              err_o
);
    logic [PORT_W-1:0] port_sync;
    logic              sample;

    cwlink_sync #(.W(PORT_W)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (port_i),
        .sync_o  (port_sync)
    );

    cwlink_timer #(.PORT_W(PORT_W), .SET_W(SET_W), .TO_W(TO_W)) u_timer (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .port_sync_i  (port_sync),
        .strobe_sel_i (strobe_sel_i),
        .settle_i     (settle_i),
        .timeout_i    (timeout_i),
        .err_clr_i    (err_clr_i),
        .sample_o     (sample),
        .err_o        (err_o)
    );

    cwlink_extract #(.PORT_W(PORT_W), .IDX_W(IDX_W)) u_extract (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .port_sync_i (port_sync),
        .sample_i    (sample),
        .valid_sel_i (valid_sel_i),
        .mask_i      (mask_i),
        .shift_i     (shift_i),
        .idx_o       (idx_o),
        .idx_vld_o   (idx_vld_o)
    );

    a_r6_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (idx_vld_o && !sample) |=> !idx_vld_o);
endmodule

// File: tb/test_cwlink_rx.sv
`timescale 1ns/1ps
module test_cwlink_rx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] port = '0;
    logic [4:0]  stb_sel = 5'd31, vld_sel = 5'd0, shift = 5'd1;
    logic [31:0] mask = 32'h0000_07FE;
    logic [3:0]  settle = 4'd2;
    logic [15:0] tmo = '0;
    logic        clr = 1'b0;
    logic [9:0]  idx;
    logic        ivld, err;
    logic        stb_lvl = 1'b0;
    int          n_chk = 0, n_bad = 0;
    bit          done = 0;

    always #2.5 clk = ~clk;

    cwlink_rx i_cwlink_rx (
        .clk_i(clk), .rst_ni(rst_n), .port_i(port),
        .strobe_sel_i(stb_sel), .valid_sel_i(vld_sel), .mask_i(mask),
        .shift_i(shift), .settle_i(settle), .timeout_i(tmo), .err_clr_i(clr),
        .idx_o(idx), .idx_vld_o(ivld), .err_o(err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // one codeword slot: strobe toggles at once, data and valid after 'skew' cycles
    task automatic slot(input logic vb, input logic [31:0] dat, input int skew,
                        input logic exp_p, input logic [9:0] exp_i, input string req);
        bit early = 0;
        @(negedge clk);
        stb_lvl = ~stb_lvl;
        port[stb_sel] = stb_lvl;
        for (int k = 0; k <= int'(settle) + 3; k++) begin
            if (k == skew) begin
                port = dat;
                port[stb_sel] = stb_lvl;
                port[vld_sel] = vb;
            end
            if (k > 0 && ivld) early = 1;
            @(negedge clk);
        end
        chk({req, " R5 no early pulse"}, 32'(early), 0);
        chk({req, " pulse"}, 32'(ivld), 32'(exp_p));
        chk({req, " index"}, 32'(idx), 32'(exp_i));
        @(negedge clk);
        chk({req, " R6 pulse width"}, 32'(ivld), 0);
    endtask

    task automatic reconfig(input logic [4:0] s, input logic [4:0] v,
                            input logic [31:0] m, input logic [4:0] sh);
        @(negedge clk);
        port = '0;
        stb_lvl = 1'b0;
        cycles(8);
        stb_sel = s; vld_sel = v; mask = m; shift = sh;
        cycles(8);
    endtask

    task automatic t_reset;
        chk("R1 index", 32'(idx), 0);
        chk("R1 pulse", 32'(ivld), 0);
        chk("R1 error", 32'(err), 0);
    endtask

    task automatic t_both_edges;
        slot(1, 32'h0000_F2AA, 0, 1, 10'h155, "R2 rising R4");
        slot(1, 32'h1234_0554, 0, 1, 10'h2AA, "R2 falling R4");
    endtask

    task automatic t_invalid;
        slot(0, 32'h0000_01E0, 0, 0, 10'h2AA, "R3 invalid slot R9");
    endtask

    task automatic t_mask;
        reconfig(5'd3, 5'd25, 32'h000F_FC00, 5'd10);
        slot(1, 32'hFFF0_F3FF, 0, 1, 10'h03C, "R4 stray bits");
        reconfig(5'd3, 5'd25, 32'h0000_3C00, 5'd10);
        slot(1, 32'h000F_FC00, 0, 1, 10'h00F, "R4 narrow mask");
        reconfig(5'd3, 5'd25, 32'hFFFF_FFFF, 5'd4);
        slot(1, 32'hABCD_E5A0, 0, 1, 10'h25A, "R4 truncation");
    endtask

    task automatic t_settle;
        reconfig(5'd31, 5'd0, 32'h0000_07FE, 5'd1);
        settle = 4'd0;
        slot(1, 32'h0000_0AAA, 0, 1, 10'h155, "R5 settle0 aligned");
        slot(1, 32'h0000_0554, 2, 1, 10'h155, "R5 settle0 late data");
        settle = 4'd3;
        slot(1, 32'h0000_07FE, 2, 1, 10'h3FF, "R5 settle3 late data");
        settle = 4'd2;
    endtask

    task automatic t_timeout;
        bit seen = 0;
        @(negedge clk);
        tmo = 16'd20;
        cycles(15);
        chk("R7 before limit", 32'(err), 0);
        cycles(10);
        chk("R7 after limit", 32'(err), 1);
        cycles(30);
        chk("R7 sticky", 32'(err), 1);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        chk("R8 cleared", 32'(err), 0);
        cycles(12);
        chk("R8 count restarted", 32'(err), 0);
        cycles(15);
        chk("R8 second timeout", 32'(err), 1);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        for (int i = 0; i < 8; i++) begin
            stb_lvl = ~stb_lvl;
            port[stb_sel] = stb_lvl;
            port[vld_sel] = 1'b0;
            for (int j = 0; j < 10; j++) begin
                if (err) seen = 1;
                @(negedge clk);
            end
        end
        chk("R7 strobe activity keeps error low", 32'(seen), 0);
        tmo = '0;
    endtask

    initial begin
        cycles(4);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_both_edges();
        t_invalid();
        t_mask();
        t_settle();
        t_timeout();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule